// File: doc/BRIEF.md
# Octal Latched Bidirectional Bus Transceiver

This block passes eight data bits from an A bus to a B bus and eight more from B to A. Each direction has its own storage element and its own three active-low controls. The latch control lets data through or holds it. The chip control gates both the latch and the output drive. The drive control turns the far bus's outputs on or off. The latch is level-sensitive in behaviour. It is built as a register that follows its input on every edge of a fast system clock while it is open, and keeps its value while it is closed.

Each bus side is a pair of vectors, one in and one out, plus an output-valid flag standing for the drive state, so no tri-state logic exists inside. A test-mode input swaps the normal paths for boundary-cell values. In this mode the latch inputs come from test vectors instead of the bus pins. The bus outputs and their drive flags come straight from test vectors. The controls keep deciding when the latches open. Scan sequencing that produces the test vectors sits outside this block.

Top module: `octal_latch_xcvr`

## Requirements
- R1: After reset both stored words are zero, so each bus output reads 0 once its drive is enabled.
- R2: With testMode low, when latchAbN and chipAbN are both 0 at a rising clock edge, the A-to-B store takes aIn. bOut shows that value from the same edge onward.
- R3: When latchAbN or chipAbN is 1 at an edge, the A-to-B store keeps its value, whatever aIn does.
- R4: With testMode low, bOe is 1 exactly when driveAbN and chipAbN are both 0, in the same cycle, with no clock delay.
- R5: The B-to-A store follows the same load and hold rule as R2 and R3, using bIn, latchBaN and chipBaN, and its value appears on aOut.
- R6: With testMode low, aOe is 1 exactly when driveBaN and chipBaN are both 0, in the same cycle.
- R7: A held value is unchanged by any sequence of drive-enable changes. It reappears on the output when drive returns.
- R8: With testMode high, bOut/bOe equal tstBOut/tstBOe and aOut/aOe equal tstAOut/tstAOe in the same cycle, whatever the stored words and controls are.
- R9: With testMode high, a store that is open loads from its test source instead of the bus. The A-to-B store loads tstAIn and the B-to-A store loads tstBIn. The loaded value shows on the normal output after testMode returns to 0.
- R10: The two directions are independent. Loading or holding one store never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the latches |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | 1 = boundary values replace the normal paths |
| latchAbN | input | 1 | A-to-B latch open when 0 |
| chipAbN | input | 1 | A-to-B chip enable, active low |
| driveAbN | input | 1 | B-side drive enable, active low |
| latchBaN | input | 1 | B-to-A latch open when 0 |
| chipBaN | input | 1 | B-to-A chip enable, active low |
| driveBaN | input | 1 | A-side drive enable, active low |
| aIn | input | 8 | Value present on the A bus |
| bIn | input | 8 | Value present on the B bus |
| tstAIn | input | 8 | Test value fed to the A-to-B latch input |
| tstBIn | input | 8 | Test value fed to the B-to-A latch input |
| tstAOut | input | 8 | Test value for the A bus output |
| tstBOut | input | 8 | Test value for the B bus output |
| tstAOe | input | 1 | Test drive flag for the A bus |
| tstBOe | input | 1 | Test drive flag for the B bus |
| aOut | output | 8 | Value driven on the A bus |
| aOe | output | 1 | A bus drive active |
| bOut | output | 8 | Value driven on the B bus |
| bOe | output | 1 | B bus drive active |

## Verification
Drive flags and everything selected by test mode follow their inputs in the same cycle. Stored data appears on the outputs one rising edge after the cycle in which the latch was open. The bench changes inputs only on falling edges. It updates its reference copies of the two stores at the rising edge, using the inputs that were stable there. It then compares all four outputs at the next falling edge, so each result is read in the cycle it is due.

// File: rtl/octal_xcvr_pkg.sv
package octal_xcvr_pkg;

  // Strobes the control passes to the datapath each cycle.
  typedef struct packed {
    logic loadAb;   // A-to-B store open
    logic loadBa;   // B-to-A store open
    logic driveB;   // B bus drive in normal mode
    logic driveA;   // A bus drive in normal mode
    logic useTest;  // boundary values replace the normal paths
  } xcvrStrobe_t;

  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;
  localparam int unsigned NUM_DIR = 2;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import octal_xcvr_pkg::*;
(
  input  logic        testMode,
  input  logic        latchAbN,
  input  logic        chipAbN,
  input  logic        driveAbN,
  input  logic        latchBaN,
  input  logic        chipBaN,
  input  logic        driveBaN,
  output xcvrStrobe_t strobe
);

  logic chipAbOn;
  logic chipBaOn;

  // The chip enable gates both the latch and the drive in each direction.
  assign chipAbOn = ~chipAbN;
  assign chipBaOn = ~chipBaN;

  always_comb begin
    strobe         = '0;
    strobe.loadAb  = chipAbOn & ~latchAbN;
    strobe.loadBa  = chipBaOn & ~latchBaN;
    strobe.driveB  = chipAbOn & ~driveAbN;
    strobe.driveA  = chipBaOn & ~driveBaN;
    strobe.useTest = testMode;
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] srcIn,
  output logic [W-1:0] held
);

  // One storage bit per channel; an open latch follows its source each edge.
  for (genvar bitIdx = 0; bitIdx < W; bitIdx++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        held[bitIdx] <= 1'b0;
      end else if (load) begin
        held[bitIdx] <= srcIn[bitIdx];
      end
    end
  end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import octal_xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  xcvrStrobe_t  strobe,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] tstAIn,
  input  logic [W-1:0] tstBIn,
  input  logic [W-1:0] tstAOut,
  input  logic [W-1:0] tstBOut,
  input  logic         tstAOe,
  input  logic         tstBOe,
  output logic [W-1:0] aOut,
  output logic         aOe,
  output logic [W-1:0] bOut,
  output logic         bOe,
  output logic [W-1:0] abHeld,
  output logic [W-1:0] baHeld
);

  logic [W-1:0] srcVec  [NUM_DIR];
  logic [W-1:0] heldVec [NUM_DIR];
  logic         loadVec [NUM_DIR];

  // Latch sources: bus pins normally, boundary values in test mode.
  assign srcVec[DIR_AB]  = strobe.useTest ? tstAIn : aIn;
  assign srcVec[DIR_BA]  = strobe.useTest ? tstBIn : bIn;
  assign loadVec[DIR_AB] = strobe.loadAb;
  assign loadVec[DIR_BA] = strobe.loadBa;

  for (genvar dirIdx = 0; dirIdx < NUM_DIR; dirIdx++) begin : g_dir
    xcvr_lane #(.W(W)) u_lane (
      .clk   (clk),
      .rstN  (rstN),
      .load  (loadVec[dirIdx]),
      .srcIn (srcVec[dirIdx]),
      .held  (heldVec[dirIdx])
    );
  end

  assign abHeld = heldVec[DIR_AB];
  assign baHeld = heldVec[DIR_BA];

  // Output selection: stored data and gated drive, or boundary values.
  always_comb begin
    if (strobe.useTest) begin
      bOut = tstBOut;
      bOe  = tstBOe;
      aOut = tstAOut;
      aOe  = tstAOe;
    end else begin
      bOut = abHeld;
      bOe  = strobe.driveB;
      aOut = baHeld;
      aOe  = strobe.driveA;
    end
  end

endmodule

// File: rtl/octal_latch_xcvr.sv
module octal_latch_xcvr
  import octal_xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         testMode,
  input  logic         latchAbN,
  input  logic         chipAbN,
  input  logic         driveAbN,
  input  logic         latchBaN,
  input  logic         chipBaN,
  input  logic         driveBaN,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic [W-1:0] tstAIn,
  input  logic [W-1:0] tstBIn,
  input  logic [W-1:0] tstAOut,
  input  logic [W-1:0] tstBOut,
  input  logic         tstAOe,
  input  logic         tstBOe,
  output logic [W-1:0] aOut,
  output logic         aOe,
  output logic [W-1:0] bOut,
  output logic         bOe
);

  xcvrStrobe_t  strobe;
  logic [W-1:0] abHeld;
  logic [W-1:0] baHeld;

  xcvr_ctrl u_ctrl (
    .testMode (testMode),
    .latchAbN (latchAbN),
    .chipAbN  (chipAbN),
    .driveAbN (driveAbN),
    .latchBaN (latchBaN),
    .chipBaN  (chipBaN),
    .driveBaN (driveBaN),
    .strobe   (strobe)
  );

  xcvr_path #(.W(W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .aIn     (aIn),
    .bIn     (bIn),
    .tstAIn  (tstAIn),
    .tstBIn  (tstBIn),
    .tstAOut (tstAOut),
    .tstBOut (tstBOut),
    .tstAOe  (tstAOe),
    .tstBOe  (tstBOe),
    .aOut    (aOut),
    .aOe     (aOe),
    .bOut    (bOut),
    .bOe     (bOe),
    .abHeld  (abHeld),
    .baHeld  (baHeld)
  );

endmodule

// File: rtl/octal_latch_xcvr_chk.sv
module octal_latch_xcvr_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         testMode,
  input logic         latchAbN,
  input logic         chipAbN,
  input logic         driveAbN,
  input logic         latchBaN,
  input logic         chipBaN,
  input logic         driveBaN,
  input logic [W-1:0] aIn,
  input logic [W-1:0] bIn,
  input logic [W-1:0] tstAIn,
  input logic [W-1:0] tstBOut,
  input logic         tstBOe,
  input logic [W-1:0] bOut,
  input logic         bOe,
  input logic         aOe,
  input logic [W-1:0] abHeld,
  input logic [W-1:0] baHeld
);

  assert_load_ab_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && !latchAbN && !chipAbN) |=> (abHeld == $past(aIn)));

  assert_hold_ab_R3: assert property (@(posedge clk) disable iff (!rstN)
    (latchAbN || chipAbN) |=> $stable(abHeld));

  assert_drive_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> (bOe == (!driveAbN && !chipAbN)));

  assert_load_ba_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && !latchBaN && !chipBaN) |=> (baHeld == $past(bIn)));

  assert_drive_a_R6: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |-> (aOe == (!driveBaN && !chipBaN)));

  assert_test_out_R8: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (bOut == tstBOut && bOe == tstBOe));

  assert_test_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !latchAbN && !chipAbN) |=> (abHeld == $past(tstAIn)));

  assert_ba_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (latchBaN || chipBaN) |=> $stable(baHeld));

endmodule

bind octal_latch_xcvr octal_latch_xcvr_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .testMode (testMode),
  .latchAbN (latchAbN),
  .chipAbN  (chipAbN),
  .driveAbN (driveAbN),
  .latchBaN (latchBaN),
  .chipBaN  (chipBaN),
  .driveBaN (driveBaN),
  .aIn      (aIn),
  .bIn      (bIn),
  .tstAIn   (tstAIn),
  .tstBOut  (tstBOut),
  .tstBOe   (tstBOe),
  .bOut     (bOut),
  .bOe      (bOe),
  .aOe      (aOe),
  .abHeld   (abHeld),
  .baHeld   (baHeld)
);

// File: tb/octal_latch_xcvr_bench.sv
`timescale 1ns/1ps
module octal_latch_xcvr_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testMode = 1'b0;
  logic latchAbN = 1'b1, chipAbN = 1'b1, driveAbN = 1'b1;
  logic latchBaN = 1'b1, chipBaN = 1'b1, driveBaN = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0, tstAIn = '0, tstBIn = '0;
  logic [W-1:0] tstAOut = '0, tstBOut = '0;
  logic tstAOe = 1'b0, tstBOe = 1'b0;
  logic [W-1:0] aOut, bOut;
  logic aOe, bOe;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] mAb = '0;
  logic [W-1:0] mBa = '0;

  always #2 clk = ~clk;

  octal_latch_xcvr #(.W(W)) u_octal_latch_xcvr (
    .clk(clk), .rstN(rstN), .testMode(testMode),
    .latchAbN(latchAbN), .chipAbN(chipAbN), .driveAbN(driveAbN),
    .latchBaN(latchBaN), .chipBaN(chipBaN), .driveBaN(driveBaN),
    .aIn(aIn), .bIn(bIn), .tstAIn(tstAIn), .tstBIn(tstBIn),
    .tstAOut(tstAOut), .tstBOut(tstBOut), .tstAOe(tstAOe), .tstBOe(tstBOe),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  function automatic logic expBOe();
    return testMode ? tstBOe : (!driveAbN && !chipAbN);
  endfunction

  function automatic logic expAOe();
    return testMode ? tstAOe : (!driveBaN && !chipBaN);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: reference stores follow the inputs stable at the rising edge.
  task automatic tick();
    @(posedge clk);
    if (!latchAbN && !chipAbN) mAb = testMode ? tstAIn : aIn;
    if (!latchBaN && !chipBaN) mBa = testMode ? tstBIn : bIn;
    @(negedge clk);
  endtask

  task automatic checkAll();
    if (testMode) begin
      chk("R8 bOut", bOut, tstBOut);
      chk("R8 aOut", aOut, tstAOut);
    end else begin
      chk("R2 bOut", bOut, mAb);
      chk("R5 aOut", aOut, mBa);
    end
    chk("R4 bOe", {7'd0, bOe}, {7'd0, expBOe()});
    chk("R6 aOe", {7'd0, aOe}, {7'd0, expAOe()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: zero after reset, drives enabled
    driveAbN = 1'b0; chipAbN = 1'b0; driveBaN = 1'b0; chipBaN = 1'b0;
    #0.1;
    chk("R1 bOut", bOut, 8'h00);
    chk("R1 aOut", aOut, 8'h00);
    // R2/R4: load A-to-B
    aIn = 8'hA5; latchAbN = 1'b0;
    tick();
    chk("R2 load", bOut, 8'hA5);
    chk("R4 on", {7'd0, bOe}, 8'h01);
    // R3: latch closed, aIn changes
    latchAbN = 1'b1; aIn = 8'h3C;
    tick();
    chk("R3 latch high", bOut, 8'hA5);
    // R3: chip high with latch open
    latchAbN = 1'b0; chipAbN = 1'b1;
    tick();
    chk("R4 off", {7'd0, bOe}, 8'h00);
    chipAbN = 1'b0; latchAbN = 1'b1;
    #0.1;
    chk("R3 chip high", bOut, 8'hA5);
    // R7: drive toggling does not disturb the held word
    for (int i = 0; i < 4; i++) begin
      driveAbN = ~driveAbN;
      aIn = aIn + 8'h11;
      tick();
    end
    driveAbN = 1'b0;
    #0.1;
    chk("R7 held", bOut, 8'hA5);
    chk("R7 oe", {7'd0, bOe}, 8'h01);
    // R5/R10: load B-to-A; A-to-B unchanged
    bIn = 8'h5A; latchBaN = 1'b0;
    tick();
    latchBaN = 1'b1;
    chk("R5 load", aOut, 8'h5A);
    chk("R10 other dir", bOut, 8'hA5);
    // R8/R9: test mode
    testMode = 1'b1; tstBOut = 8'h0F; tstBOe = 1'b1; tstAOut = 8'hF0; tstAOe = 1'b0;
    tstAIn = 8'h99; aIn = 8'h11; latchAbN = 1'b0;
    #0.1;
    chk("R8 bOut", bOut, 8'h0F);
    chk("R8 aOe", {7'd0, aOe}, 8'h00);
    tick();
    latchAbN = 1'b1; testMode = 1'b0;
    #0.1;
    chk("R9 test source", bOut, 8'h99);
    chk("R10 B-to-A kept", aOut, 8'h5A);
    mAb = 8'h99; mBa = 8'h5A;
    // Random phase against the reference
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      checkAll();
      {latchAbN, chipAbN, driveAbN, latchBaN, chipBaN, driveBaN} = 6'($urandom);
      testMode = ($urandom % 5) == 0;
      aIn = 8'($urandom); bIn = 8'($urandom);
      tstAIn = 8'($urandom); tstBIn = 8'($urandom);
      tstAOut = 8'($urandom); tstBOut = 8'($urandom);
      tstAOe = 1'($urandom); tstBOe = 1'($urandom);
      #0.1;
      checkAll();
      @(posedge clk);
      if (!latchAbN && !chipAbN) mAb = testMode ? tstAIn : aIn;
      if (!latchBaN && !chipBaN) mBa = testMode ? tstBIn : bIn;
    end
    @(negedge clk);
    checkAll();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule